// File: doc/BRIEF.md
# Little-Endian Unaligned Multi-Size Data Memory

This block is a 256-byte data store with a single port. The port reads and writes with a byte, word (2 bytes) or doubleword (4 bytes) access. The target address is a base plus a signed byte offset, and it may fall on any byte. A multi-byte access therefore runs across whatever data happens to lie next to it. Bytes are packed into and unpacked from the 32-bit data lanes with the lowest address in the least significant byte.

Reads are combinational from the address and size. Writes take effect on the rising clock edge and touch only the bytes that the size covers. Addresses past the last byte wrap to the first. The read result also appears as a pair of 16-bit halves, for a consumer that loads a 32-bit value into two adjacent 16-bit registers.

Top module: `le_byte_mem`

## Requirements
- R1: The effective address is base_i plus off_i, where off_i is a two's-complement byte offset. The sum is taken modulo 256, so offset 0 selects the byte at the base and a negative offset counts bytes backward from it.
- R2: size_i encodes the access width: 2'b00 is one byte, 2'b01 is two bytes, and 2'b10 or 2'b11 is four bytes. The byte at the effective address maps to data bits [7:0], and each following address maps to the next higher byte lane.
- R3: A write (we_i high at a rising clk_i edge) stores byte lane k of wdata_i at effective address + k for every lane that the size covers, and leaves all other bytes unchanged.
- R4: A read of fewer than four bytes is zero-extended on rdata_o: a byte read gives rdata_o[31:8] = 0, and a word read gives rdata_o[31:16] = 0.
- R5: Lane addresses that pass 255 wrap to 0, for both reads and writes.
- R6: While rst_ni is low, every byte of the store is cleared to zero.
- R7: rdata_o follows the address and size inputs combinationally, and a write becomes visible only after the clock edge. With no write and unchanged inputs, rdata_o stays the same from one cycle to the next.
- R8: lo_half_o carries rdata_o[15:0], the lower-numbered register of the pair. hi_half_o carries rdata_o[31:16], the next register.
- R9: An unaligned multi-byte read that crosses the boundary between bytes written by separate accesses returns the contiguous bytes stored at those addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes happen on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the store |
| base_i | input | 8 | Base byte address |
| off_i | input | 8 | Signed byte offset added to base_i |
| size_i | input | 2 | Access width code |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data, little-endian byte lanes |
| rdata_o | output | 32 | Zero-extended read data |
| lo_half_o | output | 16 | Low 16-bit register of the pair |
| hi_half_o | output | 16 | High 16-bit register of the pair |

## Verification
The readback and stability properties assume that base_i, off_i and size_i are unchanged between the write cycle and the cycle in which they compare. They also assume that no reset falls between the two cycles. The bench changes its inputs only on falling edges and holds them stable across each rising edge. Every write is followed by a cycle with we_i low before any read is checked. The sweeps use every address and every size, so lanes that wrap and lanes that straddle earlier writes both fall inside these assumptions.

// File: rtl/le_mem_pkg.sv
package le_mem_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_DWRD = 2'b10,
    SZ_DWRX = 2'b11
  } acc_size_e;

  function automatic int unsigned size_bytes(logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 1;
      SZ_WORD: return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/le_lane_decode.sv
module le_lane_decode
  import le_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0]             base_i,
  input  logic [ADDR_W-1:0]             off_i,
  input  logic [1:0]                    size_i,
  output logic [LANES-1:0][ADDR_W-1:0]  lane_addr_o,
  output logic [LANES-1:0]              lane_en_o
);
  localparam int CNT_W = $clog2(LANES) + 1;

  logic [ADDR_W-1:0] ea;
  logic [CNT_W-1:0]  cnt;

  // unsigned add of a two's-complement offset wraps modulo depth
  assign ea  = base_i + off_i;
  assign cnt = CNT_W'(size_bytes(size_i));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_addr_o[g] = ea + ADDR_W'(g);
    assign lane_en_o[g]   = CNT_W'(g) < cnt;
  end
endmodule

// File: rtl/le_byte_store.sv
module le_byte_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [LANES-1:0][ADDR_W-1:0]  lane_addr_i,
  input  logic [LANES-1:0]              lane_en_i,
  input  logic [LANES-1:0][7:0]         wbyte_i,
  output logic [LANES-1:0][7:0]         rbyte_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int k = 0; k < LANES; k++) begin
          if (lane_en_i[k] && lane_addr_i[k] == ADDR_W'(i)) mem_q[i] <= wbyte_i[k];
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rbyte_o[g] = mem_q[lane_addr_i[g]];
  end
endmodule

// File: rtl/le_read_merge.sv
module le_read_merge #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0][7:0] rbyte_i,
  input  logic [LANES-1:0]      lane_en_i,
  output logic [LANES*8-1:0]    rdata_o
);
  // lanes beyond the access width read as zero
  for (genvar g = 0; g < LANES; g++) begin : g_mrg
    assign rdata_o[g*8 +: 8] = lane_en_i[g] ? rbyte_i[g] : 8'h00;
  end
endmodule

// File: rtl/le_byte_mem.sv
module le_byte_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W/2-1:0] lo_half_o,
  output logic [DATA_W/2-1:0] hi_half_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;

  logic [LANES-1:0][ADDR_W-1:0] lane_addr;
  logic [LANES-1:0]             lane_en;
  logic [LANES-1:0][7:0]        wbyte;
  logic [LANES-1:0][7:0]        rbyte;

  assign wbyte = wdata_i;

  le_lane_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .base_i      (base_i),
    .off_i       (off_i),
    .size_i      (size_i),
    .lane_addr_o (lane_addr),
    .lane_en_o   (lane_en)
  );

  le_byte_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .lane_addr_i (lane_addr),
    .lane_en_i   (lane_en),
    .wbyte_i     (wbyte),
    .rbyte_o     (rbyte)
  );

  le_read_merge #(.LANES(LANES)) u_mrg (
    .rbyte_i   (rbyte),
    .lane_en_i (lane_en),
    .rdata_o   (rdata_o)
  );

  // register pair: lower-numbered register takes the low half
  assign lo_half_o = rdata_o[HALF_W-1:0];
  assign hi_half_o = rdata_o[DATA_W-1:HALF_W];
endmodule

// File: rtl/le_byte_mem_chk.sv
module le_byte_mem_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] off_i,
  input logic [1:0]        size_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W/2-1:0] lo_half_o,
  input logic [DATA_W/2-1:0] hi_half_o
);
  // R4
  byte_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i == 2'b00 |-> rdata_o[DATA_W-1:8] == '0);

  // R4
  word_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i == 2'b01 |-> hi_half_o == '0);

  // R3
  full_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(we_i) && $past(size_i) == 2'b10 && size_i == 2'b10 &&
     $stable(base_i) && $stable(off_i)) |-> rdata_o == $past(wdata_i));

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(we_i) && $stable(base_i) && $stable(off_i) &&
     $stable(size_i)) |-> $stable(rdata_o));

  // R8
  half_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_half_o[7:0] == rdata_o[7:0]);
endmodule

bind le_byte_mem le_byte_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .base_i    (base_i),
  .off_i     (off_i),
  .size_i    (size_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .lo_half_o (lo_half_o),
  .hi_half_o (hi_half_o)
);

// File: tb/sim_le_byte_mem.sv
`timescale 1ns/1ps
module sim_le_byte_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  base = '0;
  logic [7:0]  off = '0;
  logic [1:0]  size = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] lo_h, hi_h;

  int checks = 0;
  int fails = 0;
  logic [7:0] ref_m [256];

  always #2 clk = ~clk;

  le_byte_mem u0 (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base), .off_i(off), .size_i(size),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .lo_half_o(lo_h), .hi_half_o(hi_h)
  );

  function automatic int nb(logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] ea, logic [1:0] s);
    logic [31:0] v = '0;
    for (int k = 0; k < nb(s); k++) v[k*8 +: 8] = ref_m[8'(ea + 8'(k))];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b, logic [7:0] o, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    base = b; off = o; size = s; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    for (int k = 0; k < nb(s); k++) ref_m[8'(b + o + 8'(k))] = d[k*8 +: 8];
  endtask

  task automatic rd(string req, logic [7:0] b, logic [7:0] o, logic [1:0] s);
    logic [31:0] e;
    @(negedge clk);
    base = b; off = o; size = s;
    #1;
    e = exp_rd(8'(b + o), s);
    chk(req, rdata, e);
    chk("R8", {hi_h, lo_h}, e);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R6: store cleared during reset
    #1;
    chk("R6", rdata, 32'h0);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a += 4) rd("R6", 8'(a), 8'h00, 2'b10);

    // R3: fill with byte writes, then sweep every address and size
    for (int a = 0; a < 256; a++) wr(8'(a), 8'h00, 2'b00, 32'hA5A5_A500 | 32'((a * 7 + 3) & 255));
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 4; s++) rd((s == 0) ? "R4" : "R2", 8'(a), 8'h00, 2'(s));

    // R1: offset zero and negative offsets
    rd("R1", 8'h40, 8'h00, 2'b00);
    rd("R1", 8'h20, 8'hF6, 2'b10);   // -10
    rd("R1", 8'h03, 8'hFD, 2'b01);   // -3 lands on 0x00

    // R3/R9: adjacent arrays of different widths, then straddling reads
    wr(8'h80, 8'h00, 2'b00, 32'h0000_000B);
    wr(8'h81, 8'h00, 2'b01, 32'h0000_1E00);
    wr(8'h83, 8'h00, 2'b10, 32'h0000_0310);
    rd("R9", 8'h80, 8'h00, 2'b10);
    rd("R9", 8'h87, 8'hFE, 2'b10);   // 0x85 straddles into third write
    rd("R3", 8'h7F, 8'h00, 2'b00);   // neighbour below untouched
    rd("R3", 8'h87, 8'h00, 2'b00);   // neighbour above untouched

    // R3: unaligned word write leaves surroundings intact
    wr(8'h51, 8'h00, 2'b01, 32'hDEAD_BEEF);
    for (int a = 16'h4F; a < 16'h55; a++) rd("R3", 8'(a), 8'h00, 2'b00);
    rd("R4", 8'h51, 8'h00, 2'b01);

    // R5: wrap past the last byte on write and read
    wr(8'hFE, 8'h00, 2'b11, 32'h4433_2211);
    rd("R5", 8'hFE, 8'h00, 2'b10);
    rd("R5", 8'h00, 8'h00, 2'b01);
    rd("R5", 8'hFF, 8'h00, 2'b10);
    rd("R5", 8'h02, 8'h00, 2'b00);

    // R7: write invisible before edge, stable with no write
    @(negedge clk);
    base = 8'h10; off = 8'h00; size = 2'b10; wdata = 32'h1234_5678; we = 1'b1;
    #1;
    chk("R7", rdata, exp_rd(8'h10, 2'b10));
    @(negedge clk);
    we = 1'b0;
    for (int k = 0; k < 4; k++) ref_m[8'h10 + k] = wdata[k*8 +: 8];
    #1;
    chk("R7", rdata, 32'h1234_5678);
    @(negedge clk);
    #1;
    chk("R7", rdata, 32'h1234_5678);
    rd("R8", 8'h10, 8'h00, 2'b10);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule